// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a block of words between memory and a single peripheral. It takes the bus only in cycles that the processor leaves free. Software writes a start address, a word count and a direction through a small write-only register port, then issues a start command. From that point the engine runs the transfer itself as bus master. Each word has its own bus request, and a word moves only in a cycle where the arbiter grants the bus and the peripheral is asking for service. The memory address advances by one after every word.

Memory is split into pages of `2**PAGE_W` words. When a word at the last offset of a page moves and more words remain, the engine stops and pulses a segment flag. It then waits for a continue command that carries the physical base of the next page, so software can place a transfer across pages that are not adjacent in memory. When the last word has moved, a sticky interrupt flag is raised. Software clears it with a register write.

Top module: `dma_steal`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after reset, `busy_o`, `paused_o`, `seg_done_o`, `irq_o`, `bus_req_o` and `dev_ack_o` are all 0.
- R2: Register writes use `reg_sel_i` codes 0 = start address, 1 = word count (the low `CNT_W` bits of the data), 2 = direction (data bit 0). A write to any of these while `busy_o` is 1 has no effect, so a later transfer started without rewriting them uses the values written before.
- R3: `bus_req_o` is 1 exactly when the engine is running (busy and not paused) and `dev_req_i` is 1. A word moves, shown by `dev_ack_o`, exactly when `bus_req_o` and `bus_gnt_i` are both 1.
- R4: `mem_addr_o` shows the address of the current word. The first word of a transfer uses the programmed start address, and each moved word advances the address by one.
- R5: With direction bit 0 = 0 (memory to peripheral), a moved word asserts `mem_re_o` and forwards `mem_rdata_i` to `dev_wdata_o` in the same cycle. With bit 0 = 1 (peripheral to memory), it asserts `mem_we_o` and drives `mem_wdata_o` from `dev_rdata_i`. `mem_re_o` and `mem_we_o` are never 1 together.
- R6: When a word at page offset `2**PAGE_W-1` moves and words remain, the engine enters the paused state on the next cycle. `seg_done_o` is 1 for exactly that first paused cycle, and `bus_req_o` stays 0 while paused.
- R7: A continue command (code 4) while paused resumes the transfer at the address formed from the data's bits above `PAGE_W` with a zero page offset. Code 4 at any other time has no effect.
- R8: On the cycle after the last word moves, `busy_o` is 0 and `irq_o` is 1. `irq_o` stays 1 until a write with code 5. If a set and a clear fall in the same cycle, the set wins.
- R9: A start command (code 3) while `busy_o` is 1 has no effect on the running transfer.
- R10: A start command with a word count of zero moves no word, leaves `busy_o` at 0 and sets `irq_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register or command code |
| reg_wdata_i | input | ADDR_W | Register write data |
| busy_o | output | 1 | Transfer in progress (running or paused) |
| paused_o | output | 1 | Waiting at a page boundary |
| seg_done_o | output | 1 | One-cycle pulse on entering a page pause |
| irq_o | output | 1 | Sticky completion interrupt |
| bus_req_o | output | 1 | Per-word bus request |
| bus_gnt_i | input | 1 | Bus grant for the current cycle |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data (same cycle) |
| dev_req_i | input | 1 | Peripheral service request |
| dev_ack_o | output | 1 | Peripheral acknowledge, one per moved word |
| dev_wdata_o | output | DATA_W | Data to the peripheral |
| dev_rdata_i | input | DATA_W | Data from the peripheral |

## Verification
A wrong remaining count or a wrong address register shows on `mem_addr_o` at the next acknowledged word. It also shows in the cycle where `busy_o` and `irq_o` change, since completion then comes one word early or late. A wrong pause decision shows within one cycle of the word at the last page offset, through `paused_o` and `seg_done_o`. A start, continue or configuration write that is not gated correctly changes the address or the count, and the next moved word exposes it. The bench runs a behavioural reference in step with the design and compares every output on every clock, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } dma_state_e;

  localparam logic [2:0] SEL_ADDR  = 3'd0;
  localparam logic [2:0] SEL_LEN   = 3'd1;
  localparam logic [2:0] SEL_DIR   = 3'd2;
  localparam logic [2:0] SEL_START = 3'd3;
  localparam logic [2:0] SEL_CONT  = 3'd4;
  localparam logic [2:0] SEL_CLR   = 3'd5;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              idle_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  len_o,
  output logic              dir_o,
  output logic              start_o,
  output logic              cont_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] cont_base_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic              dir_q;
  logic              cfg_wr;

  // setup registers are frozen while a transfer owns them
  assign cfg_wr = we_i & idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
    end else if (cfg_wr) begin
      if (sel_i == SEL_ADDR) addr_q <= wdata_i;
      if (sel_i == SEL_LEN)  len_q  <= wdata_i[CNT_W-1:0];
      if (sel_i == SEL_DIR)  dir_q  <= wdata_i[0];
    end
  end

  assign addr_o      = addr_q;
  assign len_o       = len_q;
  assign dir_o       = dir_q;
  assign start_o     = we_i & (sel_i == SEL_START);
  assign cont_o      = we_i & (sel_i == SEL_CONT);
  assign clr_o       = we_i & (sel_i == SEL_CLR);
  assign cont_base_o = {wdata_i[ADDR_W-1 -: HI_W], {PAGE_W{1'b0}}};
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              dir_i,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] cont_base_i,
  input  logic              xfer_i,
  output logic              idle_o,
  output logic              run_o,
  output logic              pause_o,
  output logic              dir_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              seg_done_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(1);

  dma_state_e        state_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic              dir_q;
  logic              seg_q;
  logic              irq_q;
  logic              page_end;
  logic              last_word;
  logic              irq_set;

  assign page_end  = &cur_addr_q[PAGE_W-1:0];
  assign last_word = (remain_q == LAST_CNT);
  assign irq_set   = ((state_q == ST_IDLE) & start_i & (len_i == '0)) |
                     ((state_q == ST_RUN) & xfer_i & last_word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_addr_q <= '0;
      remain_q   <= '0;
      dir_q      <= 1'b0;
      seg_q      <= 1'b0;
    end else begin
      seg_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && len_i != '0) begin
            state_q    <= ST_RUN;
            cur_addr_q <= addr_i;
            remain_q   <= len_i;
            dir_q      <= dir_i;
          end
        end
        ST_RUN: begin
          if (xfer_i) begin
            cur_addr_q <= cur_addr_q + 1'b1;
            remain_q   <= remain_q - 1'b1;
            if (last_word) begin
              state_q <= ST_IDLE;
            end else if (page_end) begin
              state_q <= ST_PAUSE;
              seg_q   <= 1'b1;
            end
          end
        end
        ST_PAUSE: begin
          if (cont_i) begin
            cur_addr_q <= cont_base_i;
            state_q    <= ST_RUN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (clr_i)   irq_q <= 1'b0;
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign run_o      = (state_q == ST_RUN);
  assign pause_o    = (state_q == ST_PAUSE);
  assign dir_o      = dir_q;
  assign cur_addr_o = cur_addr_q;
  assign seg_done_o = seg_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/dma_port_mux.sv
module dma_port_mux #(
  parameter int DATA_W = 16
) (
  input  logic              run_i,
  input  logic              dir_i,
  input  logic              dev_req_i,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic              bus_req_o,
  output logic              xfer_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] dev_wdata_o
);
  // one stolen bus cycle per word, only when the peripheral is ready
  assign bus_req_o   = run_i & dev_req_i;
  assign xfer_o      = bus_req_o & bus_gnt_i;
  assign mem_re_o    = xfer_o & ~dir_i;
  assign mem_we_o    = xfer_o & dir_i;
  assign mem_wdata_o = dev_rdata_i;
  assign dev_wdata_o = mem_rdata_i;
endmodule

// File: rtl/dma_steal.sv
module dma_steal #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic              busy_o,
  output logic              paused_o,
  output logic              seg_done_o,
  output logic              irq_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              dev_req_i,
  output logic              dev_ack_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic [DATA_W-1:0] dev_rdata_i
);
  logic [ADDR_W-1:0] cfg_addr;
  logic [CNT_W-1:0]  cfg_len;
  logic              cfg_dir;
  logic              cmd_start;
  logic              cmd_cont;
  logic              cmd_clr;
  logic [ADDR_W-1:0] cont_base;
  logic              seq_idle;
  logic              seq_run;
  logic              seq_pause;
  logic              seq_dir;
  logic              xfer;

  dma_cfg_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .idle_i      (seq_idle),
    .addr_o      (cfg_addr),
    .len_o       (cfg_len),
    .dir_o       (cfg_dir),
    .start_o     (cmd_start),
    .cont_o      (cmd_cont),
    .clr_o       (cmd_clr),
    .cont_base_o (cont_base)
  );

  dma_sequencer #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (cfg_addr),
    .len_i       (cfg_len),
    .dir_i       (cfg_dir),
    .start_i     (cmd_start),
    .cont_i      (cmd_cont),
    .clr_i       (cmd_clr),
    .cont_base_i (cont_base),
    .xfer_i      (xfer),
    .idle_o      (seq_idle),
    .run_o       (seq_run),
    .pause_o     (seq_pause),
    .dir_o       (seq_dir),
    .cur_addr_o  (mem_addr_o),
    .seg_done_o  (seg_done_o),
    .irq_o       (irq_o)
  );

  dma_port_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .run_i       (seq_run),
    .dir_i       (seq_dir),
    .dev_req_i   (dev_req_i),
    .bus_gnt_i   (bus_gnt_i),
    .mem_rdata_i (mem_rdata_i),
    .dev_rdata_i (dev_rdata_i),
    .bus_req_o   (bus_req_o),
    .xfer_o      (xfer),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .dev_wdata_o (dev_wdata_o)
  );

  assign busy_o    = ~seq_idle;
  assign paused_o  = seq_pause;
  assign dev_ack_o = xfer;
endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_sel_i,
  input logic              busy_o,
  input logic              paused_o,
  input logic              seg_done_o,
  input logic              irq_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              dev_req_i,
  input logic              dev_ack_o,
  input logic              mem_re_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  AST_REQ_NEEDS_DEV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (dev_req_i && busy_o && !paused_o)); // R3
  AST_ACK_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_o |-> (bus_req_o && bus_gnt_i)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_o |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))); // R4
  AST_SEG_IN_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_done_o |-> paused_o); // R6
  AST_SEG_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_done_o |=> !seg_done_o); // R6
  AST_PAUSE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> !bus_req_o); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_we_i && reg_sel_i == 3'd5)) |=> irq_o); // R8
  AST_DONE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o); // R8
endmodule

bind dma_steal dma_steal_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .busy_o     (busy_o),
  .paused_o   (paused_o),
  .seg_done_o (seg_done_o),
  .irq_o      (irq_o),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .dev_req_i  (dev_req_i),
  .dev_ack_o  (dev_ack_o),
  .mem_re_o   (mem_re_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/dma_steal_test.sv
`timescale 1ns/1ps
module dma_steal_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 12;
  localparam int PW = 6;
  localparam int PAGE = 1 << PW;
  localparam logic [DW-1:0] MEM_KEY = 16'h5A3C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic          bus_gnt = 1'b0;
  logic          dev_req = 1'b0;
  logic [DW-1:0] dev_rdata = '0;
  logic [DW-1:0] mem_rdata;
  logic          busy, paused, seg_done, irq, bus_req, mem_re, mem_we, dev_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, dev_wdata;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference state
  int m_st = 0;       // 0 idle, 1 run, 2 pause
  int m_addr = 0, m_rem = 0, m_dir = 0, m_irq = 0, m_seg = 0;
  int r_addr = 0, r_len = 0, r_dir = 0;

  always #5 clk = ~clk;

  assign mem_rdata = mem_addr ^ MEM_KEY;

  dma_steal #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .PAGE_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .busy_o(busy), .paused_o(paused), .seg_done_o(seg_done), .irq_o(irq),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .dev_req_i(dev_req), .dev_ack_o(dev_ack),
    .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit e_req, e_ack;
    e_req = (m_st == 1) && dev_req;
    e_ack = e_req && bus_gnt;
    chk("R8 R9 busy_o", busy, m_st != 0);
    chk("R6 paused_o", paused, m_st == 2);
    chk("R6 seg_done_o", seg_done, m_seg);
    chk("R8 R10 irq_o", irq, m_irq);
    chk("R3 bus_req_o", bus_req, e_req);
    chk("R3 dev_ack_o", dev_ack, e_ack);
    chk("R5 mem_re_o", mem_re, e_ack && m_dir == 0);
    chk("R5 mem_we_o", mem_we, e_ack && m_dir == 1);
    if (e_ack) chk("R4 R7 R2 mem_addr_o", mem_addr, m_addr);
    if (e_ack && m_dir == 1) chk("R5 mem_wdata_o", mem_wdata, dev_rdata);
    if (e_ack && m_dir == 0) chk("R5 dev_wdata_o", dev_wdata, (m_addr & 16'hFFFF) ^ MEM_KEY);
  endtask

  task automatic model_step();
    int st0, set, moved;
    st0 = m_st; set = 0;
    moved = (m_st == 1) && dev_req && bus_gnt;
    m_seg = 0;
    if (moved) begin
      m_rem = m_rem - 1;
      if (m_rem == 0) begin m_st = 0; set = 1; end
      else if ((m_addr % PAGE) == PAGE - 1) begin m_st = 2; m_seg = 1; end
      m_addr = (m_addr + 1) & 16'hFFFF;
    end
    if (reg_we) begin
      case (reg_sel)
        3'd0: if (st0 == 0) r_addr = reg_wdata;
        3'd1: if (st0 == 0) r_len = reg_wdata & ((1 << CW) - 1);
        3'd2: if (st0 == 0) r_dir = reg_wdata & 1;
        3'd3: if (st0 == 0) begin           // R9: ignored when busy
          if (r_len == 0) set = 1;            // R10
          else begin m_st = 1; m_addr = r_addr; m_rem = r_len; m_dir = r_dir; end
        end
        3'd4: if (st0 == 2) begin           // R7
          m_addr = reg_wdata & ~(PAGE - 1); m_st = 1;
        end
        default: ;
      endcase
    end
    if (set) m_irq = 1;
    else if (reg_we && reg_sel == 3'd5) m_irq = 0;
  endtask

  task automatic cyc(input bit we, input int sel, input int wd, input bit dq, input bit gn);
    reg_we = we; reg_sel = sel[2:0]; reg_wdata = wd[AW-1:0];
    dev_req = dq; bus_gnt = gn; dev_rdata = $urandom();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input int wd);
    cyc(1, sel, wd, 1'b0, 1'b0);
  endtask

  // run until idle; pokes exercise R2/R9 and stray continue (R7)
  task automatic run_xfer(input int base, input bit poke, input int req_pct);
    int nb;
    nb = base;
    for (int i = 0; i < 4000 && m_st != 0; i++) begin
      bit dq, gn;
      dq = ($urandom_range(99) < req_pct);
      gn = ($urandom_range(99) < 60);
      if (m_st == 2 && $urandom_range(2) != 0) begin
        cyc(1, 4, nb, dq, gn);
        nb = nb + PAGE * 3;
      end else if (poke && m_st == 1 && $urandom_range(7) == 0) begin
        cyc(1, $urandom_range(4), $urandom(), dq, gn);
      end else begin
        cyc(0, 0, 0, dq, gn);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy_o", busy, 0);
    chk("R1 paused_o", paused, 0);
    chk("R1 irq_o", irq, 0);
    chk("R1 bus_req_o", bus_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 seg_done_o", seg_done, 0);
    chk("R1 dev_ack_o", dev_ack, 0);

    // memory to peripheral, within one page
    wr(0, 16'h0010); wr(1, 5); wr(2, 0); wr(3, 0);
    run_xfer(16'h0400, 0, 80);
    cyc(0, 0, 0, 0, 0);
    wr(5, 0);

    // peripheral to memory crossing a page, R6 R7
    wr(0, 16'h003D); wr(1, 6); wr(2, 1); wr(3, 0);
    run_xfer(16'h0283, 0, 70);
    wr(5, 0);

    // R2 R9: pokes while busy, then restart with old settings
    wr(3, 0);
    run_xfer(16'h1100, 1, 50);
    wr(3, 0);
    run_xfer(16'h2200, 0, 100);

    // R10: zero length
    wr(5, 0); wr(1, 0); wr(3, 0);
    cyc(0, 0, 0, 1, 1);
    // R8: set wins over clear (last word moves while clear written)
    wr(0, 16'h0100); wr(1, 1); wr(3, 0);
    cyc(1, 5, 0, 1, 1);
    cyc(0, 0, 0, 0, 0);
    // R7: continue when idle ignored
    wr(5, 0); wr(4, 16'hFFC0); cyc(0, 0, 0, 1, 1);

    // random mixes
    for (int k = 0; k < 60; k++) begin
      wr(0, $urandom_range(16'hFFFF));
      wr(1, $urandom_range(150));
      wr(2, $urandom_range(1));
      if ($urandom_range(3) == 0) wr(5, 0);
      wr(3, 0);
      run_xfer($urandom_range(16'hFFFF), $urandom_range(1), $urandom_range(30, 100));
      repeat (2) cyc(0, 0, 0, $urandom_range(1), $urandom_range(1));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule